// File: doc/BRIEF.md
# Configurable Replacement Victim Selector

This block chooses which way of one set of an associative cache is to be replaced. It keeps a small amount of replacement state for every set. A two-bit policy input picks the scheme applied on each miss: least-recently-used, tree pseudo-LRU, round-robin, or round-robin that steps over the most recently used way. The tag store reports each hit, and the block updates the recency state of that set. On a miss, the tag store gives the set index and a mask of which ways hold valid lines. One cycle later the block returns the way to be refilled.

The associativity is a parameter (2, 4 or 8 ways) and so is the number of sets. True LRU is exact only with two ways. With more ways, an LRU request is served by the binary pseudo-LRU tree. The way chosen on a miss counts as touched, because it is about to be filled. The block holds no tags, no data and no refill sequencing.

Top module: `victim_way_select`

## Requirements
- R1: A synchronous active-high reset clears all per-set state and drives victimValid low. After reset, the first miss to any set with all ways valid returns way 0, whatever the policy.
- R2: victimValid is high for exactly one cycle, the cycle after missValid was sampled high, and victimWay holds the choice in that cycle. A hit (accessValid) never raises victimValid. accessValid and missValid are never high together.
- R3: If wayValidMask has any bit at 0 (bit i = 1 means way i holds a valid line), the lowest-numbered invalid way is returned, whatever the policy, and the round-robin pointer does not move.
- R4: With two ways and policySel = 0 (LRU), the victim is the way that was not touched most recently. Hits and refills both count as touches.
- R5: With policySel = 1 (tree), or policySel = 0 and 4 or 8 ways, each set keeps ways-1 node bits. A touch sets every node on the path to point away from the touched way. The victim is found by walking from the root: 0 goes to the lower half and 1 to the upper half, with the most significant victim bit decided first.
- R6: With policySel = 2 (round-robin), the victim is the set's pointer. After a miss that uses the policy choice, the pointer becomes victim + 1, wrapping. Hits leave it unchanged.
- R7: With policySel = 3 (NMRU), the victim is the pointer, unless the pointer names the set's most recently touched way. In that case the next way is chosen. The pointer then becomes the chosen way + 1. Before any touch of a set, no way counts as most recently used.
- R8: A change of policySel takes effect on the next miss. All per-set state is kept across the change. Every touch updates the tree and the most-recent record in every mode. The pointer moves only on round-robin or NMRU misses.
- R9: The state of each set changes only on accesses and misses to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| accessValid | input | 1 | A hit occurred in set setIdx on way accessWay |
| accessWay | input | WAY_W | Way that hit |
| missValid | input | 1 | Miss in set setIdx; requests a victim |
| setIdx | input | SET_W | Set being accessed or missed |
| policySel | input | 2 | 0 LRU, 1 tree pseudo-LRU, 2 round-robin, 3 NMRU |
| wayValidMask | input | NUM_WAYS | Bit i high when way i holds a valid line |
| victimValid | output | 1 | victimWay is valid this cycle |
| victimWay | output | WAY_W | Way chosen for replacement |

## Verification
A wrong node bit, pointer or recency record is invisible while the set only sees hits. It shows on victimWay one cycle after the next miss that reads it. The scenarios therefore end each sequence of hits with a miss whose expected way depends on every earlier touch. Wraparound, skipping over the most recently used way, invalid-way priority and a policy switch part way through a set's history each lead to their own expected victim.

// File: rtl/evict_pkg.sv
package evict_pkg;

  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_TREE = 2'd1,
    POL_RR   = 2'd2,
    POL_NMRU = 2'd3
  } policy_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic touch;        // hit update of recency state
    logic fill;         // miss: pick a victim and touch it
    logic takeInvalid;  // an invalid way overrides the policy
    logic useTree;      // tree walk supplies the choice
    logic advancePtr;   // round-robin pointer moves
    logic allowSkip;    // step over the most recent way
  } evictCtrl_t;

endpackage

// File: rtl/evict_plru_tree.sv
module evict_plru_tree #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int TREE_W = NUM_WAYS - 1
) (
  input  logic [TREE_W-1:0] treeIn,
  input  logic [WAY_W-1:0]  touchWay,
  output logic [WAY_W-1:0]  victimWay,
  output logic [TREE_W-1:0] treeOut
);

  generate
    if (NUM_WAYS == 2) begin : g_pair
      // One bit is exact LRU: it names the way not touched last
      assign victimWay = treeIn[0];
      assign treeOut   = ~touchWay;
    end else begin : g_tree
      always_comb begin
        int node;
        node = 1;
        victimWay = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          victimWay[WAY_W-1-lvl] = treeIn[node-1];
          node = 2 * node + int'(treeIn[node-1]);
        end
      end

      always_comb begin
        int node;
        logic dirBit;
        node = 1;
        treeOut = treeIn;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          dirBit = touchWay[WAY_W-1-lvl];
          treeOut[node-1] = ~dirBit;
          node = 2 * node + int'(dirBit);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/evict_ctrl.sv
module evict_ctrl
  import evict_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accessValid,
  input  logic       missValid,
  input  logic [1:0] policySel,
  input  logic       anyInvalid,
  output evictCtrl_t ctrlOut
);

  policy_e policy;
  assign policy = policy_e'(policySel);

  always_comb begin
    ctrlOut             = '0;
    ctrlOut.fill        = missValid;
    ctrlOut.touch       = accessValid && !missValid;
    ctrlOut.takeInvalid = missValid && anyInvalid;
    ctrlOut.useTree     = (policy == POL_LRU) || (policy == POL_TREE);
    ctrlOut.allowSkip   = (policy == POL_NMRU);
    ctrlOut.advancePtr  = missValid && !anyInvalid &&
                          ((policy == POL_RR) || (policy == POL_NMRU));
  end

  // R2: hit and miss strobes are mutually exclusive
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(accessValid && missValid));

endmodule

// File: rtl/evict_dp.sv
module evict_dp
  import evict_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int TREE_W = NUM_WAYS - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  evictCtrl_t          ctrlIn,
  input  logic [WAY_W-1:0]    accessWay,
  input  logic [SET_W-1:0]    setIdx,
  input  logic [NUM_WAYS-1:0] wayValidMask,
  output logic                anyInvalid,
  output logic                victimValid,
  output logic [WAY_W-1:0]    victimWay
);

  logic [TREE_W-1:0] treeMem [NUM_SETS];
  logic [WAY_W-1:0]  ptrMem  [NUM_SETS];
  logic [WAY_W-1:0]  mruMem  [NUM_SETS];
  logic [NUM_SETS-1:0] mruKnown;

  logic [TREE_W-1:0] curTree, treeNext;
  logic [WAY_W-1:0]  curPtr, curMru;
  logic              curKnown;
  logic [WAY_W-1:0]  invalidWay, treeVictim, rrPick, pickWay, touchWay;
  logic              skipMru;

  assign curTree  = treeMem[setIdx];
  assign curPtr   = ptrMem[setIdx];
  assign curMru   = mruMem[setIdx];
  assign curKnown = mruKnown[setIdx];

  // Lowest-numbered invalid way
  always_comb begin
    invalidWay = '0;
    anyInvalid = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!wayValidMask[w]) begin
        invalidWay = WAY_W'(w);
        anyInvalid = 1'b1;
      end
    end
  end

  assign skipMru = ctrlIn.allowSkip && curKnown && (curPtr == curMru);
  assign rrPick  = skipMru ? curPtr + WAY_W'(1) : curPtr;

  always_comb begin
    if (ctrlIn.takeInvalid)  pickWay = invalidWay;
    else if (ctrlIn.useTree) pickWay = treeVictim;
    else                     pickWay = rrPick;
  end

  assign touchWay = ctrlIn.fill ? pickWay : accessWay;

  evict_plru_tree #(.NUM_WAYS(NUM_WAYS)) u_tree (
    .treeIn   (curTree),
    .touchWay (touchWay),
    .victimWay(treeVictim),
    .treeOut  (treeNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        treeMem[s] <= '0;
        ptrMem[s]  <= '0;
        mruMem[s]  <= '0;
      end
      mruKnown    <= '0;
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      if (ctrlIn.touch || ctrlIn.fill) begin
        treeMem[setIdx]  <= treeNext;
        mruMem[setIdx]   <= touchWay;
        mruKnown[setIdx] <= 1'b1;
      end
      if (ctrlIn.advancePtr) ptrMem[setIdx] <= pickWay + WAY_W'(1);
      victimValid <= ctrlIn.fill;
      if (ctrlIn.fill) victimWay <= pickWay;
    end
  end

  // R3: an invalid way is always preferred
  a_r3_invalid_first: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.fill && anyInvalid |-> !wayValidMask[pickWay]);

  // R7: NMRU never returns the known most recent way
  a_r7_nmru_avoids_mru: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.fill && ctrlIn.allowSkip && !anyInvalid && curKnown |-> pickWay != curMru);

  // R6: a hit leaves the pointer of its set alone
  a_r6_hit_keeps_pointer: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.touch |=> ptrMem[$past(setIdx)] == $past(curPtr));

  // R5: after a touch the tree no longer names the touched way
  a_r5_tree_points_away: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.touch || ctrlIn.fill) |=>
      (setIdx != $past(setIdx)) || (treeVictim != $past(touchWay)));

endmodule

// File: rtl/victim_way_select.sv
module victim_way_select
  import evict_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accessValid,
  input  logic [WAY_W-1:0]    accessWay,
  input  logic                missValid,
  input  logic [SET_W-1:0]    setIdx,
  input  logic [1:0]          policySel,
  input  logic [NUM_WAYS-1:0] wayValidMask,
  output logic                victimValid,
  output logic [WAY_W-1:0]    victimWay
);

  evictCtrl_t ctrlBus;
  logic       anyInvalid;

  evict_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .accessValid(accessValid),
    .missValid  (missValid),
    .policySel  (policySel),
    .anyInvalid (anyInvalid),
    .ctrlOut    (ctrlBus)
  );

  evict_dp #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrlIn      (ctrlBus),
    .accessWay   (accessWay),
    .setIdx      (setIdx),
    .wayValidMask(wayValidMask),
    .anyInvalid  (anyInvalid),
    .victimValid (victimValid),
    .victimWay   (victimWay)
  );

  // R2: a victim only follows a miss
  a_r2_victim_after_miss: assert property (@(posedge clk) disable iff (rst)
    victimValid |-> $past(missValid));

endmodule

// File: tb/victim_way_select_tb.sv
module victim_way_select_tb;

  localparam int SETS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // four-way instance
  logic       accessValid = 0, missValid = 0;
  logic [1:0] accessWay = 0, policySel = 0;
  logic [2:0] setIdx = 0;
  logic [3:0] wayValidMask = 4'hF;
  logic       victimValid;
  logic [1:0] victimWay;

  // two-way instance
  logic       acc2 = 0, miss2 = 0;
  logic       way2 = 0;
  logic [1:0] pol2 = 0;
  logic [2:0] set2 = 0;
  logic [1:0] mask2 = 2'b11;
  logic       vv2;
  logic       vw2;

  victim_way_select #(.NUM_WAYS(4), .NUM_SETS(SETS)) u_dut (
    .clk(clk), .rst(rst), .accessValid(accessValid), .accessWay(accessWay),
    .missValid(missValid), .setIdx(setIdx), .policySel(policySel),
    .wayValidMask(wayValidMask), .victimValid(victimValid), .victimWay(victimWay));

  victim_way_select #(.NUM_WAYS(2), .NUM_SETS(SETS)) u_dut2 (
    .clk(clk), .rst(rst), .accessValid(acc2), .accessWay(way2),
    .missValid(miss2), .setIdx(set2), .policySel(pol2),
    .wayValidMask(mask2), .victimValid(vv2), .victimWay(vw2));

  int checks = 0;
  int fails = 0;
  int expQ[$];
  string tagQ[$];
  int expQ2[$];
  string tagQ2[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (!rst && victimValid) begin
      if (expQ.size() == 0) check(0, "R2 unexpected victim", 1, 0);
      else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(victimWay) == e, t, int'(victimWay), e);
      end
    end
    if (!rst && vv2) begin
      if (expQ2.size() == 0) check(0, "R2 unexpected victim (2-way)", 1, 0);
      else begin
        int e;
        string t;
        e = expQ2.pop_front();
        t = tagQ2.pop_front();
        check(int'(vw2) == e, t, int'(vw2), e);
      end
    end
  end

  task automatic doMiss(input int s, input int pol, input logic [3:0] mask,
                        input int exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    missValid = 1; setIdx = 3'(s); policySel = 2'(pol); wayValidMask = mask;
    @(negedge clk);
    missValid = 0; wayValidMask = 4'hF;
  endtask

  task automatic doHit(input int s, input int w);
    accessValid = 1; setIdx = 3'(s); accessWay = 2'(w);
    @(negedge clk);
    accessValid = 0;
  endtask

  task automatic miss2w(input int s, input int exp, input string tag);
    expQ2.push_back(exp);
    tagQ2.push_back(tag);
    miss2 = 1; set2 = 3'(s); pol2 = 2'd0;
    @(negedge clk);
    miss2 = 0;
  endtask

  task automatic hit2w(input int s, input int w);
    acc2 = 1; set2 = 3'(s); way2 = w[0];
    @(negedge clk);
    acc2 = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(victimValid == 0, "R1 victimValid low after reset", int'(victimValid), 0);

    // R1: first victim is way 0 for every policy
    doMiss(0, 2, 4'hF, 0, "R1 first victim round-robin");
    doMiss(1, 1, 4'hF, 0, "R1 first victim tree");
    doMiss(6, 3, 4'hF, 0, "R1 first victim NMRU");

    // R3: invalid ways first, pointer untouched
    doMiss(2, 2, 4'b1010, 0, "R3 lowest invalid way 0");
    doMiss(2, 2, 4'b1011, 2, "R3 lowest invalid way 2");
    doMiss(2, 2, 4'hF, 0, "R3 pointer kept after invalid fills");

    // R6: round-robin, hits ignored, wrap
    doMiss(2, 2, 4'hF, 1, "R6 pointer advance");
    doHit(2, 3);
    check(victimValid == 0, "R2 hit gives no victim", int'(victimValid), 0);
    doMiss(2, 2, 4'hF, 2, "R6 hit leaves pointer");
    doMiss(2, 2, 4'hF, 3, "R6 pointer advance");
    doMiss(2, 2, 4'hF, 0, "R6 pointer wrap");

    // R5: tree walk after four hits
    doHit(4, 0); doHit(4, 1); doHit(4, 2); doHit(4, 3);
    doMiss(4, 1, 4'hF, 0, "R5 tree after hits");
    doMiss(4, 1, 4'hF, 2, "R5 tree after fill 0");
    doMiss(4, 1, 4'hF, 1, "R5 tree after fill 2");
    doMiss(4, 0, 4'hF, 3, "R5 LRU request served by tree");

    // R7: NMRU skip
    doHit(5, 0);
    doMiss(5, 3, 4'hF, 1, "R7 skip most recent way");
    doMiss(5, 3, 4'hF, 2, "R7 pointer not most recent");
    doHit(5, 3);
    doMiss(5, 3, 4'hF, 0, "R7 skip with wrap");

    // R8: policy switches keep state
    doMiss(5, 2, 4'hF, 1, "R8 round-robin after NMRU");
    doMiss(5, 1, 4'hF, 2, "R8 tree after mixed history");
    doMiss(5, 2, 4'hF, 2, "R8 pointer kept across tree miss");

    // R9: other sets unaffected
    doMiss(0, 2, 4'hF, 1, "R9 set 0 pointer independent");
    doMiss(1, 2, 4'hF, 0, "R9 set 1 pointer independent");
    doMiss(7, 2, 4'hF, 0, "R9 fresh set 7");
    doMiss(7, 2, 4'hF, 1, "R2 back-to-back miss");

    // R4: two-way exact LRU
    miss2w(1, 0, "R4 first fill");
    miss2w(1, 1, "R4 other way after fill");
    hit2w(1, 0);
    miss2w(1, 1, "R4 hit on 0 leaves 1");
    hit2w(1, 1);
    miss2w(1, 0, "R4 hit on 1 leaves 0");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all victims seen", expQ.size(), 0);
    check(expQ2.size() == 0, "R2 all victims seen (2-way)", expQ2.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

endmodule